// File: doc/BRIEF.md
# I2C Target Engine with Event Status Codes

This block is a byte-level I2C target (slave) controlled through a small register file. Software programs a 7-bit bus address, an acknowledge-enable bit and an engine-enable bit, then waits for the interrupt flag. Each bus event leaves an 8-bit code in a read-only status register. Events are own address matched, general call matched, byte received, byte sent, and stop or repeated start while addressed. The code tells software what to do next. While the flag is up, the engine stretches the clock by holding SCL low after the acknowledge bit, so the bus waits for software between bytes.

The block runs as a receiver when the matched address carries the write bit, and as a transmitter when it carries the read bit. The acknowledge-enable bit decides two things: whether the address is recognised at all, and whether the next received byte is acknowledged. In transmit mode, the same bit marks a byte as the last one. After that byte the engine drops off the bus and only releases SDA, so the master reads all ones. SCL and SDA pass through two-flop synchronizers. The outputs are open-drain enables: a 1 pulls the line low.

Register selects: 0 = status (read only), 1 = data, 2 = own address (bits 7..1 address, bit 0 general-call enable), 3 = control (bit 6 enable, bit 5 and bit 4 start/stop requests with no effect in target operation, bit 3 interrupt flag, bit 2 acknowledge enable, bits 7 and 1..0 rate bits with no effect).

Top module: `i2c_status_slave`

## Requirements
- R1: After reset the status register reads F8h, the control and own-address registers read 00h, irq is 0 and neither SCL nor SDA is pulled low.
- R2: With enable=1 and ack-enable=1, the own 7-bit address followed by the write bit (0) is acknowledged by pulling SDA low in the ninth clock. The status then becomes 60h and irq rises.
- R3: While the flag (control bit 3) is 1, SCL is held low once it has gone low. Writing 1 to bit 3 leaves the flag set. Writing 0 clears it, releases SCL and returns the status to F8h.
- R4: A data byte received while addressed goes to the data register. If ack-enable is 1 when the eighth bit ends, the byte is acknowledged with status 80h. Otherwise SDA stays released, the status is 88h, and the engine becomes not-addressed, so a following stop raises no event.
- R5: With own-address bit 0 set, the address 00h is acknowledged with status 70h, and the following data byte gives 90h (ack) or 98h (nack). With bit 0 clear, address 00h is not acknowledged and raises no event.
- R6: The own address with the read bit (1) is acknowledged with status A8h. The byte software then loads into the data register is driven MSB first.
- R7: After a sent byte, a master acknowledge gives status B8h. A master not-acknowledge gives C0h and leaves the engine not-addressed.
- R8: If ack-enable is 0 when the flag is cleared before a sent byte, a master acknowledge of that byte gives status C8h. Any further byte reads as FFh with no new event.
- R9: While ack-enable is 0, the own address is not acknowledged and raises no event. Setting ack-enable again restores recognition.
- R10: A stop or a repeated start while addressed as receiver gives status A0h with irq raised.
- R11: With enable=0 the engine acknowledges nothing and raises no event.
- R12: An address other than the own address and the general call is not acknowledged and raises no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| irq | output | 1 | Interrupt flag |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |

## Verification
The bench drives a bus master that honours clock stretching, and goes after the points where the acknowledge-enable bit is sampled. A design that sampled it at the wrong moment would acknowledge a byte that should get a NACK, or keep answering after 88h. On reads it checks that the last byte marked by a cleared ack-enable ends in C8h and then all ones. A design that kept transmitting would return stale data instead of FFh. It also checks that stop and repeated start raise A0h only while the engine is addressed as receiver, that writing 1 to the flag cannot release a stretched SCL, and that general call depends on the enable bit in the own-address register.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  localparam int DW = 8;
  localparam int CW = $clog2(DW + 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_RX, ST_RACK, ST_TX, ST_TACK
  } eng_st_e;

  localparam logic [7:0] SC_IDLE       = 8'hF8;
  localparam logic [7:0] SC_SLAW_ACK   = 8'h60;
  localparam logic [7:0] SC_GCALL_ACK  = 8'h70;
  localparam logic [7:0] SC_DATA_ACK   = 8'h80;
  localparam logic [7:0] SC_DATA_NACK  = 8'h88;
  localparam logic [7:0] SC_GDATA_ACK  = 8'h90;
  localparam logic [7:0] SC_GDATA_NACK = 8'h98;
  localparam logic [7:0] SC_STOP_RX    = 8'hA0;
  localparam logic [7:0] SC_SLAR_ACK   = 8'hA8;
  localparam logic [7:0] SC_TX_ACK     = 8'hB8;
  localparam logic [7:0] SC_TX_NACK    = 8'hC0;
  localparam logic [7:0] SC_TX_LAST    = 8'hC8;

  localparam logic [1:0] RS_STATUS = 2'd0;
  localparam logic [1:0] RS_DATA   = 2'd1;
  localparam logic [1:0] RS_OWNADR = 2'd2;
  localparam logic [1:0] RS_CTRL   = 2'd3;

  localparam int CB_ENA  = 6;
  localparam int CB_FLAG = 3;
  localparam int CB_ACK  = 2;
endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
  parameter int LINES  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] raw,
  output logic [LINES-1:0] lvl,
  output logic [LINES-1:0] rise,
  output logic [LINES-1:0] fall
);
  generate
    for (genvar g = 0; g < LINES; g++) begin : g_line
      logic [STAGES:0] chain_q;
      logic [STAGES:0] chain_d;
      assign chain_d = {chain_q[STAGES-1:0], raw[g]};
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
      end
      assign lvl[g]  = chain_q[STAGES-1];
      assign rise[g] = chain_q[STAGES-1] & ~chain_q[STAGES];
      assign fall[g] = ~chain_q[STAGES-1] & chain_q[STAGES];
    end
  endgenerate
endmodule

// File: rtl/i2cs_regs.sv
module i2cs_regs
  import i2cs_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [1:0]    sel,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata,
  input  logic          ev_valid,
  input  logic [7:0]    ev_code,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_byte,
  output logic [6:0]    own_addr,
  output logic          gc_en,
  output logic          ena,
  output logic          aa,
  output logic          flag,
  output logic [DW-1:0] tx_byte
);
  logic [7:0]    oar_q, oar_d;
  logic [7:0]    ctl_q, ctl_d;
  logic [DW-1:0] dat_q, dat_d;
  logic [7:0]    stat_q, stat_d;
  logic          flag_q, flag_d;
  logic          oar_en, ctl_en, dat_en;

  always_comb begin
    oar_en = we && (sel == RS_OWNADR);
    ctl_en = we && (sel == RS_CTRL);
    dat_en = (we && (sel == RS_DATA)) || rx_valid;
    oar_d  = wdata;
    ctl_d  = wdata;
    ctl_d[CB_FLAG] = 1'b0;
    dat_d  = rx_valid ? rx_byte : wdata[DW-1:0];
    flag_d = flag_q;
    stat_d = stat_q;
    if (ctl_en && !wdata[CB_FLAG]) begin
      flag_d = 1'b0;
      stat_d = SC_IDLE;
    end
    if (ev_valid) begin
      flag_d = 1'b1;
      stat_d = ev_code;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oar_q  <= '0;
      ctl_q  <= '0;
      dat_q  <= '0;
      stat_q <= SC_IDLE;
      flag_q <= 1'b0;
    end else begin
      if (oar_en) oar_q <= oar_d;
      if (ctl_en) ctl_q <= ctl_d;
      if (dat_en) dat_q <= dat_d;
      stat_q <= stat_d;
      flag_q <= flag_d;
    end
  end

  always_comb begin
    case (sel)
      RS_STATUS: rdata = stat_q;
      RS_DATA:   rdata = dat_q;
      RS_OWNADR: rdata = oar_q;
      default: begin
        rdata = ctl_q;
        rdata[CB_FLAG] = flag_q;
      end
    endcase
  end

  assign own_addr = oar_q[7:1];
  assign gc_en    = oar_q[0];
  assign ena      = ctl_q[CB_ENA];
  assign aa       = ctl_q[CB_ACK];
  assign flag     = flag_q;
  assign tx_byte  = dat_q;

  p_idle_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_q |-> (stat_q == SC_IDLE));
  p_event_raises_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |=> flag_q);
  p_write_one_keeps_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && we && (sel == RS_CTRL) && wdata[CB_FLAG]) |=> flag_q);
endmodule

// File: rtl/i2cs_engine.sv
module i2cs_engine
  import i2cs_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_lvl,
  input  logic          sda_lvl,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          sda_rise,
  input  logic          sda_fall,
  input  logic          scl_prev_hi,
  input  logic [6:0]    own_addr,
  input  logic          gc_en,
  input  logic          ena,
  input  logic          aa,
  input  logic          flag,
  input  logic [DW-1:0] tx_byte,
  output logic          ev_valid,
  output logic [7:0]    ev_code,
  output logic          rx_valid,
  output logic [DW-1:0] rx_byte,
  output logic          scl_oe,
  output logic          sda_oe
);
  localparam logic [CW-1:0] FULL = CW'(DW);

  eng_st_e       st_q, st_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [DW-1:0] sh_q, sh_n;
  logic [DW-1:0] txsh_q, txsh_n;
  logic          gc_q, gc_n;
  logic          ackd_q, ackd_n;
  logic          mack_q, mack_n;
  logic          last_q, last_n;
  logic          fl_d_q;
  logic          hold_q, hold_n;
  logic          start_ev, stop_ev, rx_addr;
  logic          own_hit, gc_hit;

  assign start_ev = sda_fall && scl_lvl && scl_prev_hi;
  assign stop_ev  = sda_rise && scl_lvl && scl_prev_hi;
  assign rx_addr  = (st_q == ST_RX) || (st_q == ST_RACK);
  assign own_hit  = aa && (sh_q[DW-1:1] == own_addr);
  assign gc_hit   = aa && gc_en && (sh_q == '0);

  always_comb begin
    st_n     = st_q;
    cnt_n    = cnt_q;
    sh_n     = sh_q;
    txsh_n   = txsh_q;
    gc_n     = gc_q;
    ackd_n   = ackd_q;
    mack_n   = mack_q;
    last_n   = last_q;
    ev_valid = 1'b0;
    ev_code  = SC_IDLE;
    rx_valid = 1'b0;
    if (!ena) begin
      st_n  = ST_IDLE;
      cnt_n = '0;
    end else if (start_ev) begin
      if (rx_addr) begin
        ev_valid = 1'b1;
        ev_code  = SC_STOP_RX;
      end
      st_n  = ST_ADDR;
      cnt_n = '0;
    end else if (stop_ev) begin
      if (rx_addr) begin
        ev_valid = 1'b1;
        ev_code  = SC_STOP_RX;
      end
      st_n = ST_IDLE;
    end else begin
      case (st_q)
        ST_ADDR: begin
          if (scl_rise) begin
            sh_n  = {sh_q[DW-2:0], sda_lvl};
            cnt_n = cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == FULL) begin
            if (own_hit || gc_hit) begin
              st_n = ST_AACK;
              gc_n = gc_hit;
            end else begin
              st_n = ST_IDLE;
            end
          end
        end
        ST_AACK: begin
          if (scl_fall) begin
            ev_valid = 1'b1;
            cnt_n    = '0;
            if (gc_q) begin
              ev_code = SC_GCALL_ACK;
              st_n    = ST_RX;
            end else if (sh_q[0]) begin
              ev_code = SC_SLAR_ACK;
              st_n    = ST_TX;
              txsh_n  = '1;
            end else begin
              ev_code = SC_SLAW_ACK;
              st_n    = ST_RX;
            end
          end
        end
        ST_RX: begin
          if (scl_rise) begin
            sh_n  = {sh_q[DW-2:0], sda_lvl};
            cnt_n = cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == FULL) begin
            ackd_n = aa;
            st_n   = ST_RACK;
          end
        end
        ST_RACK: begin
          if (scl_fall) begin
            ev_valid = 1'b1;
            rx_valid = 1'b1;
            cnt_n    = '0;
            if (gc_q) ev_code = ackd_q ? SC_GDATA_ACK : SC_GDATA_NACK;
            else      ev_code = ackd_q ? SC_DATA_ACK  : SC_DATA_NACK;
            st_n = ackd_q ? ST_RX : ST_IDLE;
          end
        end
        ST_TX: begin
          if (cnt_q == '0 && fl_d_q && !flag) begin
            txsh_n = tx_byte;
            last_n = ~aa;
          end
          if (scl_rise) begin
            cnt_n = cnt_q + 1'b1;
          end else if (scl_fall) begin
            if (cnt_q == FULL) st_n = ST_TACK;
            else               txsh_n = {txsh_q[DW-2:0], 1'b1};
          end
        end
        ST_TACK: begin
          if (scl_rise) begin
            mack_n = ~sda_lvl;
          end else if (scl_fall) begin
            ev_valid = 1'b1;
            cnt_n    = '0;
            if (!mack_q) begin
              ev_code = SC_TX_NACK;
              st_n    = ST_IDLE;
            end else if (last_q) begin
              ev_code = SC_TX_LAST;
              st_n    = ST_IDLE;
            end else begin
              ev_code = SC_TX_ACK;
              st_n    = ST_TX;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign hold_n = (flag || fl_d_q) && (hold_q || !scl_lvl);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      sh_q   <= '0;
      txsh_q <= '1;
      gc_q   <= 1'b0;
      ackd_q <= 1'b0;
      mack_q <= 1'b0;
      last_q <= 1'b0;
      fl_d_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      cnt_q  <= cnt_n;
      sh_q   <= sh_n;
      txsh_q <= txsh_n;
      gc_q   <= gc_n;
      ackd_q <= ackd_n;
      mack_q <= mack_n;
      last_q <= last_n;
      fl_d_q <= flag;
      hold_q <= hold_n;
    end
  end

  assign rx_byte = sh_q;
  assign scl_oe  = hold_q;
  assign sda_oe  = (st_q == ST_AACK) || ((st_q == ST_RACK) && ackd_q) ||
                   ((st_q == ST_TX) && !txsh_q[DW-1]);

  p_hold_follows_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    scl_oe |-> ($past(flag) || $past(flag, 2)));
  p_ack_needs_aa_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_AACK && $past(st_q) == ST_ADDR) |-> $past(aa));
  p_quiet_when_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!ena && !$past(ena)) |-> !sda_oe);
  p_tx_bit_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_TX && $past(st_q) == ST_TX && scl_lvl && $past(scl_lvl)) |-> $stable(sda_oe));
  p_b8_continues_tx_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_code == SC_TX_ACK) |=> (st_q == ST_TX));
endmodule

// File: rtl/i2c_status_slave.sv
module i2c_status_slave
  import i2cs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_we,
  input  logic [1:0] reg_sel,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_oe,
  output logic       sda_oe
);
  logic          rst_meta_q, rst_sync_q;
  logic [1:0]    lvl, rise, fall;
  logic          scl_prev_hi;
  logic          ev_valid, rx_valid;
  logic [7:0]    ev_code;
  logic [DW-1:0] rx_byte, tx_byte;
  logic [6:0]    own_addr;
  logic          gc_en, ena, aa, flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  i2cs_sync #(.LINES(2), .STAGES(2)) u_sync (
    .clk  (clk),
    .rst_n(rst_sync_q),
    .raw  ({sda_i, scl_i}),
    .lvl  (lvl),
    .rise (rise),
    .fall (fall)
  );

  assign scl_prev_hi = lvl[0] & ~rise[0];

  i2cs_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .we      (reg_we),
    .sel     (reg_sel),
    .wdata   (reg_wdata),
    .rdata   (reg_rdata),
    .ev_valid(ev_valid),
    .ev_code (ev_code),
    .rx_valid(rx_valid),
    .rx_byte (rx_byte),
    .own_addr(own_addr),
    .gc_en   (gc_en),
    .ena     (ena),
    .aa      (aa),
    .flag    (flag),
    .tx_byte (tx_byte)
  );

  i2cs_engine u_engine (
    .clk        (clk),
    .rst_n      (rst_sync_q),
    .scl_lvl    (lvl[0]),
    .sda_lvl    (lvl[1]),
    .scl_rise   (rise[0]),
    .scl_fall   (fall[0]),
    .sda_rise   (rise[1]),
    .sda_fall   (fall[1]),
    .scl_prev_hi(scl_prev_hi),
    .own_addr   (own_addr),
    .gc_en      (gc_en),
    .ena        (ena),
    .aa         (aa),
    .flag       (flag),
    .tx_byte    (tx_byte),
    .ev_valid   (ev_valid),
    .ev_code    (ev_code),
    .rx_valid   (rx_valid),
    .rx_byte    (rx_byte),
    .scl_oe     (scl_oe),
    .sda_oe     (sda_oe)
  );

  assign irq = flag;
endmodule

// File: tb/i2c_status_slave_bench.sv
`timescale 1ns/1ps
module i2c_status_slave_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       reg_we;
  logic [1:0] reg_sel;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       irq, scl_oe, sda_oe;
  logic       scl_m, sda_m;
  logic       scl_line, sda_line;
  int         n_chk = 0;
  int         n_bad = 0;
  int         cycles = 0;

  assign scl_line = scl_m & ~scl_oe;
  assign sda_line = sda_m & ~sda_oe;

  always #5 clk = ~clk;

  i2c_status_slave u_i2c_status_slave (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .scl_i(scl_line), .sda_i(sda_line), .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  typedef struct packed {
    logic       aa;
    logic       gc;
    logic [7:0] adr;
    logic [7:0] dat;
    logic       daa;
    logic       ack;
    logic [7:0] c_adr;
    logic [7:0] c_dat;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{1'b1, 1'b0, 8'hB4, 8'h3C, 1'b1, 1'b1, 8'h60, 8'h80},
    '{1'b1, 1'b0, 8'hB4, 8'hA5, 1'b0, 1'b1, 8'h60, 8'h88},
    '{1'b1, 1'b1, 8'h00, 8'h81, 1'b1, 1'b1, 8'h70, 8'h90},
    '{1'b1, 1'b1, 8'h00, 8'h7E, 1'b0, 1'b1, 8'h70, 8'h98},
    '{1'b1, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 8'hF8, 8'hF8},
    '{1'b1, 1'b0, 8'hB6, 8'h00, 1'b0, 1'b0, 8'hF8, 8'hF8},
    '{1'b0, 1'b0, 8'hB4, 8'h00, 1'b0, 1'b0, 8'hF8, 8'hF8},
    '{1'b1, 1'b0, 8'hB4, 8'h5A, 1'b1, 1'b1, 8'h60, 8'h80}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_reg(input logic [1:0] s, input logic [7:0] v);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = s; reg_wdata = v;
    @(negedge clk);
    reg_we = 1'b0;
    cyc(2);
  endtask

  task automatic rd_reg(input logic [1:0] s, output logic [7:0] v);
    @(negedge clk);
    reg_sel = s;
    #1 v = reg_rdata;
  endtask

  task automatic bus_hi();
    @(negedge clk);
    scl_m = 1'b1;
    do @(negedge clk); while (!scl_line);
    cyc(8);
  endtask

  task automatic bus_lo();
    @(negedge clk);
    scl_m = 1'b0;
    cyc(10);
  endtask

  task automatic bus_start();
    @(negedge clk); sda_m = 1'b1;
    cyc(4);
    bus_hi();
    sda_m = 1'b0;
    cyc(8);
    bus_lo();
  endtask

  task automatic bus_stop();
    @(negedge clk); sda_m = 1'b0;
    cyc(4);
    bus_hi();
    sda_m = 1'b1;
    cyc(10);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk); sda_m = b[i];
      cyc(4);
      bus_hi();
      bus_lo();
    end
    @(negedge clk); sda_m = 1'b1;
    cyc(4);
    bus_hi();
    acked = ~sda_line;
    bus_lo();
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    b = '0;
    @(negedge clk); sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      bus_hi();
      b = {b[6:0], sda_line};
      bus_lo();
    end
    @(negedge clk); sda_m = ~mack;
    cyc(4);
    bus_hi();
    bus_lo();
    @(negedge clk); sda_m = 1'b1;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    logic [7:0] v;
    logic       ak;
    string      ta, td;
    rst_n = 1'b0; reg_we = 1'b0; reg_sel = 2'd0; reg_wdata = '0;
    scl_m = 1'b1; sda_m = 1'b1;
    cyc(5);
    rst_n = 1'b1;
    cyc(5);

    // R1 reset state
    rd_reg(2'd0, v); chk("R1 status", v, 8'hF8);
    rd_reg(2'd3, v); chk("R1 control", v, 8'h00);
    rd_reg(2'd2, v); chk("R1 own address", v, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);
    chk("R1 line drive", {6'd0, scl_oe, sda_oe}, 8'h00);

    // table-driven write transfers
    for (int k = 0; k < 8; k++) begin
      ta = !VECS[k].ack ? (VECS[k].gc || VECS[k].adr == 8'h00 ? "R5" :
                           (VECS[k].aa ? "R12" : "R9"))
                        : (VECS[k].gc ? "R5" : (k == 7 ? "R9" : "R2"));
      td = VECS[k].gc ? "R5" : "R4";
      wr_reg(2'd2, {7'h5A, VECS[k].gc});
      wr_reg(2'd3, {1'b0, 1'b1, 3'b000, VECS[k].aa, 2'b00});
      bus_start();
      send_byte(VECS[k].adr, ak);
      chk({ta, " address ack"}, {7'd0, ak}, {7'd0, VECS[k].ack});
      chk({ta, " irq after address"}, {7'd0, irq}, {7'd0, VECS[k].ack});
      rd_reg(2'd0, v); chk({ta, " address status"}, v, VECS[k].c_adr);
      if (VECS[k].ack) begin
        wr_reg(2'd3, {1'b0, 1'b1, 3'b000, VECS[k].daa, 2'b00});
        rd_reg(2'd0, v); chk("R3 status after clear", v, 8'hF8);
        send_byte(VECS[k].dat, ak);
        chk({td, " data ack"}, {7'd0, ak}, {7'd0, VECS[k].daa});
        rd_reg(2'd0, v); chk({td, " data status"}, v, VECS[k].c_dat);
        rd_reg(2'd1, v); chk("R4 data register", v, VECS[k].dat);
        wr_reg(2'd3, 8'h44);
        bus_stop();
        chk(VECS[k].daa ? "R10 irq after stop" : "R4 no event after nack",
            {7'd0, irq}, {7'd0, VECS[k].daa});
        if (VECS[k].daa) begin
          rd_reg(2'd0, v); chk("R10 stop status", v, 8'hA0);
          wr_reg(2'd3, 8'h44);
        end
      end else begin
        bus_stop();
        chk({ta, " irq after stop"}, {7'd0, irq}, 8'h00);
      end
    end

    // R6 R7 R3 transmitter with stretch checks
    wr_reg(2'd2, 8'hB4);
    wr_reg(2'd3, 8'h44);
    bus_start();
    send_byte(8'hB5, ak);
    chk("R6 read address ack", {7'd0, ak}, 8'h01);
    rd_reg(2'd0, v); chk("R6 status", v, 8'hA8);
    @(negedge clk); scl_m = 1'b1;
    cyc(40);
    chk("R3 scl held", {7'd0, scl_line}, 8'h00);
    wr_reg(2'd3, 8'h4C);
    cyc(20);
    chk("R3 write one keeps flag", {7'd0, irq}, 8'h01);
    chk("R3 scl still held", {7'd0, scl_line}, 8'h00);
    wr_reg(2'd1, 8'hC3);
    wr_reg(2'd3, 8'h44);
    recv_byte(1'b1, v);
    chk("R6 first byte", v, 8'hC3);
    rd_reg(2'd0, v); chk("R7 ack status", v, 8'hB8);
    wr_reg(2'd1, 8'h5E);
    wr_reg(2'd3, 8'h44);
    recv_byte(1'b0, v);
    chk("R6 second byte", v, 8'h5E);
    rd_reg(2'd0, v); chk("R7 nack status", v, 8'hC0);
    wr_reg(2'd3, 8'h44);
    bus_stop();
    chk("R7 not addressed after nack", {7'd0, irq}, 8'h00);

    // R8 last byte then all ones
    bus_start();
    send_byte(8'hB5, ak);
    rd_reg(2'd0, v); chk("R8 read address status", v, 8'hA8);
    wr_reg(2'd1, 8'h96);
    wr_reg(2'd3, 8'h40);
    recv_byte(1'b1, v);
    chk("R8 last byte", v, 8'h96);
    rd_reg(2'd0, v); chk("R8 last status", v, 8'hC8);
    wr_reg(2'd3, 8'h44);
    recv_byte(1'b1, v);
    chk("R8 all ones", v, 8'hFF);
    chk("R8 no event", {7'd0, irq}, 8'h00);
    bus_stop();

    // R10 repeated start while receiver
    bus_start();
    send_byte(8'hB4, ak);
    rd_reg(2'd0, v); chk("R2 address status", v, 8'h60);
    wr_reg(2'd3, 8'h44);
    send_byte(8'h11, ak);
    rd_reg(2'd0, v); chk("R4 status before restart", v, 8'h80);
    wr_reg(2'd3, 8'h44);
    bus_start();
    chk("R10 irq on restart", {7'd0, irq}, 8'h01);
    rd_reg(2'd0, v); chk("R10 restart status", v, 8'hA0);
    wr_reg(2'd3, 8'h44);
    send_byte(8'hB4, ak);
    chk("R2 ack after restart", {7'd0, ak}, 8'h01);
    rd_reg(2'd0, v); chk("R2 status after restart", v, 8'h60);
    wr_reg(2'd3, 8'h44);
    bus_stop();
    rd_reg(2'd0, v); chk("R10 stop status", v, 8'hA0);
    wr_reg(2'd3, 8'h44);

    // R11 engine disabled
    wr_reg(2'd3, 8'h04);
    bus_start();
    send_byte(8'hB4, ak);
    chk("R11 no ack when disabled", {7'd0, ak}, 8'h00);
    chk("R11 no event", {7'd0, irq}, 8'h00);
    bus_stop();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule